// File: doc/BRIEF.md
# Offset-Compensating Execute Unit

This block is the execute stage of a processor whose instruction set folds constant offsets into every operation. Each arithmetic instruction carries constants: the unit removes one offset from each operand, applies the operation, then adds a result offset. Conditional branches compare the first operand against the second operand plus a constant. When the test holds, the branch reports how many following instructions the fetch logic must skip. Operands arrive already decrypted as 32-bit words. All arithmetic wraps modulo 2^32.

One instruction may be presented per cycle with `in_valid`. The result, the branch decision and the skip distance appear on registered outputs one cycle later, with `out_valid`. The fetch logic adds the skip distance to its program counter. Division by zero after offset removal gives a defined result and raises a flag.

Top module: `ofs_exec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears `out_valid`, `result`, `taken`, `skip_out` and `div_zero` to zero.
- R2: Add (opcode 0) returns `opa + opb + k0`, wrapped to 32 bits. `k1` and `k2` have no effect on the result.
- R3: Subtract (opcode 1) returns `opa - opb + k0`, wrapped to 32 bits. `k1` and `k2` have no effect on the result.
- R4: Multiply (opcode 2) and xor (opcode 4) return `(opa - k1) op (opb - k2) + k0`. For multiply, only the low 32 bits are kept.
- R5: Divide (opcode 3) returns `(opa - k1) / (opb - k2) + k0`. The division is signed two's complement and truncates toward zero. The case -2^31 / -1 wraps to -2^31 before `k0` is added.
- R6: If the divide's offset-corrected divisor is zero, `result` is `k0 + 0xFFFFFFFF` and `div_zero` is 1. For every other instruction, `div_zero` is 0.
- R7: Branches compare `opa` against `opb + k0`, computed after wrap. The opcodes are eq=8, ne=9, lt=10, gt=11, le=12 and ge=13. The ordered tests are signed. When the test holds, `taken` is 1 and `skip_out` equals `skip_in`. Otherwise both are 0. Branches return `result` 0.
- R8: Jump (opcode 14) is always taken, with `skip_out = skip_in`. Move (opcode 5) returns `opa` unchanged, whatever the constants hold. Neither sets `div_zero`.
- R9: All outputs update on the clock edge at which `in_valid` is high. `out_valid` is high in exactly the cycle after an accepted instruction. Without `in_valid`, the data outputs keep their last values.
- R10: The opcodes 6, 7 and 15 are undefined. They return `result` 0 with `taken` 0 and `div_zero` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| k0 | input | 32 | Result offset, also the branch and add/subtract constant |
| k1 | input | 32 | Offset removed from `opa` |
| k2 | input | 32 | Offset removed from `opb` |
| skip_in | input | 8 | Instructions to skip if a branch is taken |
| out_valid | output | 1 | Registered outputs hold a new instruction's outcome |
| result | output | 32 | Arithmetic result |
| taken | output | 1 | Branch taken |
| skip_out | output | 8 | Skip distance for the fetch logic |
| div_zero | output | 1 | Divide with a zero offset-corrected divisor |

## Verification
The hardest cases to reach are those where the offsets, not the raw operands, decide the outcome. Examples are a divisor that becomes zero or -1 only after `k2` is removed, and a branch bound `opb + k0` that wraps across the sign boundary. The stimulus picks the raw operands and constants backwards from the desired corrected values. It also repeats add and subtract with different `k1`/`k2`, to show at `result` that those fields are ignored.

// File: rtl/ofs_exec_pkg.sv
// Shared opcode type for the offset-compensating execute unit.
// Assumes a 4-bit opcode field. Codes not listed are undefined.
package ofs_exec_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_XOR = 4'd4,
        OP_MOV = 4'd5,
        OP_BEQ = 4'd8,
        OP_BNE = 4'd9,
        OP_BLT = 4'd10,
        OP_BGT = 4'd11,
        OP_BLE = 4'd12,
        OP_BGE = 4'd13,
        OP_JMP = 4'd14
    } op_e;
endpackage

// File: rtl/ofs_arith.sv
// Combinational arithmetic for offset-compensated operations.
// Assumes the operands are plain two's complement words. Non-arithmetic opcodes give 0.
module ofs_arith
    import ofs_exec_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] k0,
    input  logic [W-1:0] k1,
    input  logic [W-1:0] k2,
    output logic [W-1:0] res,
    output logic         dz
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0]        ea;
    logic [W-1:0]        eb;
    logic signed [W-1:0] quot;

    // Remove operand offsets, apply the operation, add the result offset.
    always_comb begin
        ea   = a - k1;
        eb   = b - k2;
        quot = '0;
        dz   = 1'b0;
        res  = '0;
        case (op)
            OP_ADD: res = a + b + k0;
            OP_SUB: res = a - b + k0;
            OP_MUL: res = (ea * eb) + k0;
            OP_XOR: res = (ea ^ eb) + k0;
            OP_MOV: res = a;
            OP_DIV: begin
                if (eb == '0) begin
                    dz  = 1'b1;
                    res = k0 + ALL_ONES;
                end else if (eb == ALL_ONES) begin
                    res = (0 - ea) + k0;
                end else begin
                    quot = $signed(ea) / $signed(eb);
                    res  = quot + k0;
                end
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ofs_branch.sv
// Branch decision: compares a against b + k (after wrap) and gives the skip distance.
// Assumes the ordered compares are signed. Non-branch opcodes are never taken.
module ofs_branch
    import ofs_exec_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 8
) (
    input  op_e           op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  k,
    input  logic [SW-1:0] skip_in,
    output logic          taken,
    output logic [SW-1:0] skip_out
);
    logic [W-1:0] bound;

    // Evaluate the branch condition against the offset bound.
    always_comb begin
        bound = b + k;
        case (op)
            OP_BEQ:  taken = (a == bound);
            OP_BNE:  taken = (a != bound);
            OP_BLT:  taken = ($signed(a) <  $signed(bound));
            OP_BGT:  taken = ($signed(a) >  $signed(bound));
            OP_BLE:  taken = ($signed(a) <= $signed(bound));
            OP_BGE:  taken = ($signed(a) >= $signed(bound));
            OP_JMP:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
        skip_out = taken ? skip_in : '0;
    end
endmodule

// File: rtl/ofs_exec_unit.sv
// Execute stage with offset-compensated arithmetic and skip-style branches.
// One instruction per cycle. Outputs are registered one cycle after in_valid.
// Assumes the operands are already decrypted. Reset is synchronous and active low.
module ofs_exec_unit
    import ofs_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] k0,
    input  logic [DATA_W-1:0] k1,
    input  logic [DATA_W-1:0] k2,
    input  logic [SKIP_W-1:0] skip_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              taken,
    output logic [SKIP_W-1:0] skip_out,
    output logic              div_zero
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    op_e               op;
    logic [DATA_W-1:0] a_res;
    logic              a_dz;
    logic              b_tk;
    logic [SKIP_W-1:0] b_skip;

    assign op = op_e'(opcode);

    ofs_arith #(.W(DATA_W)) u_arith (
        .op (op),
        .a  (opa),
        .b  (opb),
        .k0 (k0),
        .k1 (k1),
        .k2 (k2),
        .res(a_res),
        .dz (a_dz)
    );

    ofs_branch #(.W(DATA_W), .SW(SKIP_W)) u_branch (
        .op      (op),
        .a       (opa),
        .b       (opb),
        .k       (k0),
        .skip_in (skip_in),
        .taken   (b_tk),
        .skip_out(b_skip)
    );

    // Output register: capture the outcome of an accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            taken     <= 1'b0;
            skip_out  <= '0;
            div_zero  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= a_res;
                taken    <= b_tk;
                skip_out <= b_skip;
                div_zero <= a_dz;
            end
        end
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(taken));
    assert_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd0) |=> result == $past(opa + opb + k0));
    assert_divzero_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && div_zero) |-> result == $past(k0) + ALL_ONES);
    assert_divzero_only_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && div_zero) |-> $past(opcode) == 4'd3);
    assert_not_taken_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> skip_out == '0);
    assert_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd14) |=> taken && skip_out == $past(skip_in));
endmodule

// File: tb/test_ofs_exec_unit.sv
// Directed bench for the offset-compensating execute unit.
module test_ofs_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] opa = '0, opb = '0, k0 = '0, k1 = '0, k2 = '0;
    logic [7:0]  skip_in = '0;
    logic        out_valid, taken, div_zero;
    logic [31:0] result;
    logic [7:0]  skip_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ofs_exec_unit i_ofs_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .opa(opa), .opb(opb), .k0(k0), .k1(k1), .k2(k2), .skip_in(skip_in),
        .out_valid(out_valid), .result(result), .taken(taken),
        .skip_out(skip_out), .div_zero(div_zero)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one instruction at a falling edge. Sample one cycle later, at the next falling edge.
    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2,
                         input logic [7:0] sk);
        @(negedge clk);
        opcode = op; opa = a; opb = b; k0 = c0; k1 = c1; k2 = c2; skip_in = sk;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic arith_case(input string req, input logic [3:0] op, input logic [31:0] a,
                              input logic [31:0] b, input logic [31:0] c0, input logic [31:0] c1,
                              input logic [31:0] c2, input logic [31:0] exp, input logic exp_dz);
        issue(op, a, b, c0, c1, c2, 8'd0);
        chk(req, {31'd0, out_valid}, 32'd1);
        chk(req, result, exp);
        chk(req, {31'd0, div_zero}, {31'd0, exp_dz});
        chk(req, {31'd0, taken}, 32'd0);
    endtask

    task automatic branch_case(input string req, input logic [3:0] op, input logic [31:0] a,
                               input logic [31:0] b, input logic [31:0] c0, input logic [7:0] sk,
                               input logic exp_t);
        issue(op, a, b, c0, 32'h1234, 32'h5678, sk);
        chk(req, {31'd0, taken}, {31'd0, exp_t});
        chk(req, {24'd0, skip_out}, exp_t ? {24'd0, sk} : 32'd0);
        chk(req, result, 32'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 taken", {31'd0, taken}, 32'd0);
        chk("R1 skip", {24'd0, skip_out}, 32'd0);
        chk("R1 dz", {31'd0, div_zero}, 32'd0);
    endtask

    task automatic test_add_sub();
        arith_case("R2 add", 4'd0, 32'd10, 32'd20, 32'd5, 32'd0, 32'd0, 32'd35, 1'b0);
        arith_case("R2 add k1k2 ignored", 4'd0, 32'd10, 32'd20, 32'd5, 32'hDEAD, 32'hBEEF, 32'd35, 1'b0);
        arith_case("R2 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 32'd1, 32'd7, 32'd9, 32'd1, 1'b0);
        arith_case("R3 sub", 4'd1, 32'd5, 32'd9, 32'd2, 32'd0, 32'd0, 32'hFFFF_FFFE, 1'b0);
        arith_case("R3 sub k1k2 ignored", 4'd1, 32'd5, 32'd9, 32'd2, 32'hFFFF, 32'h3, 32'hFFFF_FFFE, 1'b0);
    endtask

    task automatic test_mul_xor();
        // (13-3)*(9-2)+4 = 74
        arith_case("R4 mul", 4'd2, 32'd13, 32'd9, 32'd4, 32'd3, 32'd2, 32'd74, 1'b0);
        // (0x10000+0)*(0x10000)+0 wraps to 0
        arith_case("R4 mul wrap", 4'd2, 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, 32'd0, 32'd0, 1'b0);
        // (0xF0-0x10)^(0x0F-0x0F)+1 = 0xE1
        arith_case("R4 xor", 4'd4, 32'hF0, 32'h0F, 32'd1, 32'h10, 32'h0F, 32'hE1, 1'b0);
    endtask

    task automatic test_div();
        // (50-8)/(12-6)+1 = 8
        arith_case("R5 div", 4'd3, 32'd50, 32'd12, 32'd1, 32'd8, 32'd6, 32'd8, 1'b0);
        // (3-10)=-7, (5-3)=2, -7/2 = -3, +100 = 97
        arith_case("R5 div trunc", 4'd3, 32'd3, 32'd5, 32'd100, 32'd10, 32'd3, 32'd97, 1'b0);
        // corrected divisor -1 only after k2 removal: (0x80000000)/(-1) = 0x80000000, +0
        arith_case("R5 div overflow", 4'd3, 32'h8000_0000, 32'd4, 32'd0, 32'd0, 32'd5, 32'h8000_0000, 1'b0);
        // corrected divisor (7-7)=0: result k0-1
        arith_case("R6 div zero", 4'd3, 32'd99, 32'd7, 32'd20, 32'd1, 32'd7, 32'd19, 1'b1);
        arith_case("R6 dz clears", 4'd0, 32'd1, 32'd1, 32'd0, 32'd0, 32'd0, 32'd2, 1'b0);
    endtask

    task automatic test_branches();
        branch_case("R7 beq taken", 4'd8, 32'd15, 32'd10, 32'd5, 8'd3, 1'b1);
        branch_case("R7 beq not", 4'd8, 32'd15, 32'd10, 32'd4, 8'd3, 1'b0);
        branch_case("R7 bne", 4'd9, 32'd15, 32'd10, 32'd4, 8'd7, 1'b1);
        // bound 0x7FFFFFFF+1 wraps to most negative: 0 > bound signed
        branch_case("R7 blt wrap", 4'd10, 32'd0, 32'h7FFF_FFFF, 32'd1, 8'd2, 1'b0);
        branch_case("R7 bgt wrap", 4'd11, 32'd0, 32'h7FFF_FFFF, 32'd1, 8'd2, 1'b1);
        branch_case("R7 blt signed", 4'd10, 32'hFFFF_FFFF, 32'd0, 32'd0, 8'd9, 1'b1);
        branch_case("R7 ble equal", 4'd12, 32'd6, 32'd2, 32'd4, 8'd1, 1'b1);
        branch_case("R7 bge less", 4'd13, 32'd5, 32'd2, 32'd4, 8'd1, 1'b0);
        branch_case("R7 bge equal", 4'd13, 32'd6, 32'd2, 32'd4, 8'd255, 1'b1);
    endtask

    task automatic test_jmp_mov_undef();
        branch_case("R8 jmp", 4'd14, 32'd1, 32'd2, 32'd3, 8'd12, 1'b1);
        arith_case("R8 mov", 4'd5, 32'hCAFE_F00D, 32'd1, 32'd77, 32'd3, 32'd4, 32'hCAFE_F00D, 1'b0);
        arith_case("R10 undef 6", 4'd6, 32'd9, 32'd9, 32'd9, 32'd9, 32'd9, 32'd0, 1'b0);
        arith_case("R10 undef 15", 4'd15, 32'd9, 32'd9, 32'd9, 32'd9, 32'd9, 32'd0, 1'b0);
    endtask

    task automatic test_valid_hold();
        issue(4'd0, 32'd100, 32'd1, 32'd0, 32'd0, 32'd0, 8'd0);
        chk("R9 valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        opcode = 4'd1; opa = 32'd500;
        @(negedge clk);
        chk("R9 valid low", {31'd0, out_valid}, 32'd0);
        chk("R9 hold", result, 32'd101);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_add_sub();
        test_mul_xor();
        test_div();
        test_branches();
        test_jmp_mov_undef();
        test_valid_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule